// File: doc/BRIEF.md
# Host Bus FIFO Direct Burst Reader

This block is the slave-side read port of an asynchronous 16-bit host bus. The bus has an active-low chip select and an active-low read strobe. A host read is framed only while both strobes are low. The cycle closes the moment either strobe rises. The two strobes may fall and rise in any order. The port samples both strobes in its local clock domain, recognises the opening and closing of each cycle, and enables its output data driver only while a cycle is in progress. A pad-level buffer keyed by `hb_data_oe` turns the data pair into a tri-state bus.

A FIFO-select input picks the target of each read. When the input is high during a read, address bits A[7:3] carry no meaning and every cycle returns the next word of the receive FIFO. A host whose address auto-increments can therefore stream any number of back-to-back reads out of the FIFO. Address bits A[2:1] are still decoded in this mode and go out with the pop as a lane number. When the input is low, the read goes to a register-read port addressed by A[7:1], and the FIFO is left untouched. If the FIFO is empty in FIFO mode, the port returns zero, flags an underrun and does not pop.

The controller has four states:
- `ST_IDLE` waits for a cycle.
- `ST_CAPTURE` latches the target and the read word.
- `ST_DRIVE` holds the bus enabled.
- `ST_CLOSE` retires the cycle.

The transitions are:
- open: IDLE to CAPTURE, when both synchronized strobes are low.
- latch: CAPTURE to DRIVE, unconditional.
- release: DRIVE to CLOSE, when either synchronized strobe is high.
- rearm: CLOSE to IDLE, unconditional.

Top module: `hbus_fifo_burst_rd`

## Requirements
- R1: While `rst_n` is low, `hb_data_oe`, `fifo_pop`, `rx_underrun` and `reg_rd_strobe` are 0.
- R2: A cycle opens only when both `hb_cs_n` and `hb_rd_n` are sampled low. With only one of them low, the bus stays disabled and neither a pop nor a register strobe occurs.
- R3: Each strobe passes through a two-flop synchronizer. If both strobes are first seen low before clock edge n, `hb_data_oe` is 0 after edges n+1 and n+2 and becomes 1 after edge n+3.
- R4: Either strobe rising closes the cycle, whichever strobe fell first. If a rise is first seen before edge n, `hb_data_oe` stays 1 after edges n and n+1 and is 0 after edge n+2.
- R5: In FIFO mode (`hb_fsel`=1), the data is the FIFO head word. Address bits `hb_addr[6:2]` (A[7:3]) have no effect. `fifo_lane` equals `hb_addr[1:0]` (A[2:1]) captured at the start of the cycle.
- R6: A non-empty FIFO-mode cycle pops exactly once: a one-cycle `fifo_pop` in the cycle right after `hb_data_oe` falls. Holding the strobes low longer adds no pop.
- R7: Any number of back-to-back FIFO-mode cycles return consecutive FIFO words in order.
- R8: In FIFO mode with `fifo_empty`=1 at capture, the data is 0000h, `rx_underrun` pulses for one cycle where the pop would have been, and `fifo_pop` stays 0.
- R9: In register mode (`hb_fsel`=0), `reg_rd_strobe` pulses for one cycle, with `reg_rd_addr` = `hb_addr` (A[7:1]). The data returned is `reg_rd_data` from that cycle. The FIFO is not popped.
- R10: `hb_data_oe` is 1 only in the drive state. While it is 1, `hb_data_o` holds the captured word unchanged. Otherwise `hb_data_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hb_cs_n | input | 1 | Host chip select, active low, asynchronous |
| hb_rd_n | input | 1 | Host read strobe, active low, asynchronous |
| hb_fsel | input | 1 | FIFO-select; high routes the read to the receive FIFO |
| hb_addr | input | 7 | Host address A[7:1] |
| hb_data_o | output | 16 | Read data toward the pad buffer |
| hb_data_oe | output | 1 | Pad buffer enable; bus is high-impedance when 0 |
| fifo_rdata | input | 16 | Receive FIFO head word |
| fifo_empty | input | 1 | Receive FIFO has no word |
| fifo_pop | output | 1 | One-cycle pop of the FIFO head |
| fifo_lane | output | 2 | A[2:1] captured for the current FIFO cycle |
| rx_underrun | output | 1 | One-cycle pulse on a FIFO read while empty |
| reg_rd_strobe | output | 1 | One-cycle register read request |
| reg_rd_addr | output | 7 | Register address A[7:1] during the strobe, else 0 |
| reg_rd_data | input | 16 | Register read data, valid in the strobe cycle |

## Verification
The assertions rely on the host meeting its bus timing, translated into local clocks:
- Every both-low phase and every gap between cycles lasts several clocks.
- The address and FIFO-select lines are stable from before the strobes fall until after both have risen.
- The FIFO's empty state changes only through this port's own pops.

The stimulus drives every strobe, address and select change at the falling clock edge. It holds each strobe phase for at least three clocks, so the synchronizer never sees a runt pulse. The only agent that takes words out of the FIFO model is `fifo_pop`.

// File: rtl/hbfr_pkg.sv
package hbfr_pkg;

    // Controller states of the burst reader.
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_CAPTURE = 2'd1,
        ST_DRIVE   = 2'd2,
        ST_CLOSE   = 2'd3
    } hbfr_state_e;

    // Number of low address bits (A[2:1]) still decoded in FIFO mode.
    localparam int HBFR_LANE_W = 2;

endpackage

// File: rtl/hbfr_sync.sv
module hbfr_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);

    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= RST_VAL;
                    else        chain[0] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= RST_VAL;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/hbfr_ctrl.sv
module hbfr_ctrl
    import hbfr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cyc_act,
    output hbfr_state_e state,
    output logic        cap_en,
    output logic        drive_en,
    output logic        close_en
);

    hbfr_state_e state_q, state_d;

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (cyc_act)  state_d = ST_CAPTURE;  // open
            ST_CAPTURE:               state_d = ST_DRIVE;    // latch
            ST_DRIVE:   if (!cyc_act) state_d = ST_CLOSE;    // release
            ST_CLOSE:                 state_d = ST_IDLE;     // rearm
            default:                  state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Per-state outputs.
    always_comb begin
        cap_en   = 1'b0;
        drive_en = 1'b0;
        close_en = 1'b0;
        unique case (state_q)
            ST_IDLE:    ;
            ST_CAPTURE: cap_en   = 1'b1;
            ST_DRIVE:   drive_en = 1'b1;
            ST_CLOSE:   close_en = 1'b1;
            default:    ;
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/hbfr_capture.sv
module hbfr_capture
    import hbfr_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 7
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cap_en,
    input  logic                   drive_en,
    input  logic                   close_en,
    input  logic                   hb_fsel,
    input  logic [AW-1:0]          hb_addr,
    input  logic [DW-1:0]          fifo_rdata,
    input  logic                   fifo_empty,
    input  logic [DW-1:0]          reg_rd_data,
    output logic [DW-1:0]          hb_data_o,
    output logic                   fifo_pop,
    output logic [HBFR_LANE_W-1:0] fifo_lane,
    output logic                   rx_underrun,
    output logic                   reg_rd_strobe,
    output logic [AW-1:0]          reg_rd_addr
);

    logic                   fsel_q;
    logic                   empty_q;
    logic [HBFR_LANE_W-1:0] lane_q;
    logic [DW-1:0]          word_q;
    logic [DW-1:0]          word_d;

    // In FIFO mode the upper address bits are discarded; only the lane bits survive.
    always_comb begin
        if (hb_fsel) word_d = fifo_empty ? '0 : fifo_rdata;
        else         word_d = reg_rd_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsel_q  <= 1'b0;
            empty_q <= 1'b0;
            lane_q  <= '0;
            word_q  <= '0;
        end else if (cap_en) begin
            fsel_q  <= hb_fsel;
            empty_q <= fifo_empty;
            lane_q  <= hb_addr[HBFR_LANE_W-1:0];
            word_q  <= word_d;
        end
    end

    assign hb_data_o     = drive_en ? word_q : '0;
    assign fifo_pop      = close_en & fsel_q & ~empty_q;
    assign rx_underrun   = close_en & fsel_q & empty_q;
    assign fifo_lane     = lane_q;
    assign reg_rd_strobe = cap_en & ~hb_fsel;
    assign reg_rd_addr   = reg_rd_strobe ? hb_addr : '0;

endmodule

// File: rtl/hbus_fifo_burst_rd.sv
module hbus_fifo_burst_rd
    import hbfr_pkg::*;
#(
    parameter int DW          = 16,
    parameter int AW          = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   hb_cs_n,
    input  logic                   hb_rd_n,
    input  logic                   hb_fsel,
    input  logic [AW-1:0]          hb_addr,
    output logic [DW-1:0]          hb_data_o,
    output logic                   hb_data_oe,
    input  logic [DW-1:0]          fifo_rdata,
    input  logic                   fifo_empty,
    output logic                   fifo_pop,
    output logic [HBFR_LANE_W-1:0] fifo_lane,
    output logic                   rx_underrun,
    output logic                   reg_rd_strobe,
    output logic [AW-1:0]          reg_rd_addr,
    input  logic [DW-1:0]          reg_rd_data
);

    localparam int NSTROBE = 2;

    logic [NSTROBE-1:0] strb_sync;
    logic               cyc_act;
    hbfr_state_e        state;
    logic               cap_en;
    logic               drive_en;
    logic               close_en;

    hbfr_sync #(
        .WIDTH   (NSTROBE),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ({NSTROBE{1'b1}})
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({hb_cs_n, hb_rd_n}),
        .q_sync  (strb_sync)
    );

    // A cycle exists only while both synchronized strobes are low.
    assign cyc_act = ~|strb_sync;

    hbfr_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cyc_act  (cyc_act),
        .state    (state),
        .cap_en   (cap_en),
        .drive_en (drive_en),
        .close_en (close_en)
    );

    hbfr_capture #(
        .DW (DW),
        .AW (AW)
    ) u_capture (
        .clk           (clk),
        .rst_n         (rst_n),
        .cap_en        (cap_en),
        .drive_en      (drive_en),
        .close_en      (close_en),
        .hb_fsel       (hb_fsel),
        .hb_addr       (hb_addr),
        .fifo_rdata    (fifo_rdata),
        .fifo_empty    (fifo_empty),
        .reg_rd_data   (reg_rd_data),
        .hb_data_o     (hb_data_o),
        .fifo_pop      (fifo_pop),
        .fifo_lane     (fifo_lane),
        .rx_underrun   (rx_underrun),
        .reg_rd_strobe (reg_rd_strobe),
        .reg_rd_addr   (reg_rd_addr)
    );

    assign hb_data_oe = (state == ST_DRIVE);

endmodule

// File: rtl/hbus_fifo_burst_rd_chk.sv
module hbus_fifo_burst_rd_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          hb_cs_n,
    input logic          hb_rd_n,
    input logic          hb_data_oe,
    input logic [DW-1:0] hb_data_o,
    input logic          fifo_pop,
    input logic          fifo_empty,
    input logic          rx_underrun,
    input logic          reg_rd_strobe
);

    // R2: the bus can only turn on after both raw strobes were seen low.
    assert_start_needs_both_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hb_data_oe) |-> $past(!hb_cs_n && !hb_rd_n, 4));

    // R6: the pop comes right after the drive phase, never during it.
    assert_pop_after_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> ($past(hb_data_oe) && !hb_data_oe));

    // R6: a pop is a single-cycle pulse.
    assert_single_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |=> !fifo_pop);

    // R8: pop and underrun are mutually exclusive.
    assert_pop_xor_underrun_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fifo_pop, rx_underrun}));

    // R8: an empty FIFO is never popped.
    assert_no_pop_when_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> !fifo_empty);

    // R9: a register request is a single-cycle pulse and never coincides with a pop.
    assert_reg_strobe_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_strobe |=> !reg_rd_strobe);

    assert_reg_strobe_no_pop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_strobe |-> !fifo_pop);

    // R10: data held steady while the driver stays on.
    assert_data_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (hb_data_oe && $past(hb_data_oe)) |-> $stable(hb_data_o));

endmodule

bind hbus_fifo_burst_rd hbus_fifo_burst_rd_chk #(.DW(DW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .hb_cs_n       (hb_cs_n),
    .hb_rd_n       (hb_rd_n),
    .hb_data_oe    (hb_data_oe),
    .hb_data_o     (hb_data_o),
    .fifo_pop      (fifo_pop),
    .fifo_empty    (fifo_empty),
    .rx_underrun   (rx_underrun),
    .reg_rd_strobe (reg_rd_strobe)
);

// File: tb/hbus_fifo_burst_rd_tb.sv
module hbus_fifo_burst_rd_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        rd_n = 1'b1;
    logic        fsel = 1'b0;
    logic [6:0]  addr = '0;
    logic [15:0] data_o;
    logic        data_oe;
    logic [15:0] fifo_rdata = '0;
    logic        fifo_empty = 1'b1;
    logic        fifo_pop;
    logic [1:0]  fifo_lane;
    logic        underrun;
    logic        reg_strobe;
    logic [6:0]  reg_addr;
    logic [15:0] reg_data;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    logic [15:0] q[$];

    always #10 clk = ~clk;  // 50 MHz

    hbus_fifo_burst_rd u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .hb_cs_n       (cs_n),
        .hb_rd_n       (rd_n),
        .hb_fsel       (fsel),
        .hb_addr       (addr),
        .hb_data_o     (data_o),
        .hb_data_oe    (data_oe),
        .fifo_rdata    (fifo_rdata),
        .fifo_empty    (fifo_empty),
        .fifo_pop      (fifo_pop),
        .fifo_lane     (fifo_lane),
        .rx_underrun   (underrun),
        .reg_rd_strobe (reg_strobe),
        .reg_rd_addr   (reg_addr),
        .reg_rd_data   (reg_data)
    );

    assign reg_data = {9'h0B3, reg_addr};

    task automatic chk(input string req, input int act, input int exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
        end
    endtask

    task automatic refresh();
        fifo_empty = (q.size() == 0);
        fifo_rdata = (q.size() != 0) ? q[0] : 16'h0;
    endtask

    // Behavioural reference: strobe delay line plus cycle phase counter.
    int  m_s1 = 0, m_s2 = 0, m_phase = 0;
    int  e_fsel = 0, e_empty = 0, e_data = 0, e_lane = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_phase = 0;
        end else begin
            case (m_phase)
                0: if (m_s2 != 0) m_phase = 1;
                1: begin
                    e_fsel  = fsel;
                    e_empty = (q.size() == 0);
                    e_lane  = addr[1:0];
                    if (fsel) e_data = (q.size() != 0) ? q[0] : 0;
                    else      e_data = {9'h0B3, addr};
                    m_phase = 2;
                end
                2: if (m_s2 == 0) m_phase = 3;
                default: m_phase = 0;
            endcase
            m_s2 = m_s1;
            m_s1 = (!cs_n && !rd_n) ? 1 : 0;
            if (fifo_pop) begin
                void'(q.pop_front());
                refresh();
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R10 oe", data_oe, m_phase == 2);
            if (m_phase == 2) chk(e_fsel ? "R5 data" : "R9 data", data_o, e_data);
            else              chk("R10 idle data", data_o, 0);
            chk("R6 pop", fifo_pop, m_phase == 3 && e_fsel != 0 && e_empty == 0);
            chk("R8 underrun", underrun, m_phase == 3 && e_fsel != 0 && e_empty != 0);
            chk("R9 strobe", reg_strobe, m_phase == 1 && !fsel);
            chk("R9 addr", reg_addr, (m_phase == 1 && !fsel) ? addr : 0);
            if (m_phase == 3 && e_fsel != 0) chk("R5 lane", fifo_lane, e_lane);
        end
    end

    // One host read; first_cs picks the falling order, endsel picks which strobe rises first.
    task automatic host_read(input bit fs, input logic [6:0] a, input bit first_cs, input int endsel);
        bit    will_pop = fs && (q.size() != 0);
        int    exp_word = (fs && q.size() != 0) ? q[0] : 0;
        @(negedge clk); fsel = fs; addr = a;
        @(negedge clk); if (first_cs) cs_n = 1'b0; else rd_n = 1'b0;
        repeat (3) begin
            @(negedge clk);
            chk("R2 one strobe oe", data_oe, 0);
            chk("R2 one strobe reg", reg_strobe, 0);
        end
        if (first_cs) rd_n = 1'b0; else cs_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R3 still off", data_oe, 0);
        @(negedge clk);
        chk("R3 on", data_oe, 1);
        if (fs) chk("R7 next word", data_o, exp_word);
        repeat (2) @(negedge clk);
        case (endsel)
            0:       cs_n = 1'b1;
            1:       rd_n = 1'b1;
            default: begin cs_n = 1'b1; rd_n = 1'b1; end
        endcase
        repeat (2) begin @(negedge clk); chk("R4 held", data_oe, 1); end
        @(negedge clk);
        chk("R4 closed", data_oe, 0);
        chk("R6 one pop", fifo_pop, will_pop);
        chk("R8 flag", underrun, fs && !will_pop);
        cs_n = 1'b1; rd_n = 1'b1;
        @(negedge clk);
        chk("R6 no second pop", fifo_pop, 0);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        refresh();
        repeat (3) @(negedge clk);
        chk("R1 oe", data_oe, 0);
        chk("R1 pop", fifo_pop, 0);
        chk("R1 underrun", underrun, 0);
        chk("R1 strobe", reg_strobe, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R2: each strobe alone, held long.
        cs_n = 1'b0; fsel = 1'b1;
        repeat (8) begin @(negedge clk); chk("R2 cs only", data_oe | fifo_pop | reg_strobe, 0); end
        cs_n = 1'b1;
        repeat (3) @(negedge clk);
        rd_n = 1'b0; fsel = 1'b0;
        repeat (8) begin @(negedge clk); chk("R2 rd only", data_oe | fifo_pop | reg_strobe, 0); end
        rd_n = 1'b1;
        repeat (3) @(negedge clk);

        // R5, R7: burst with a scrambled upper address on every read.
        for (int i = 0; i < 24; i++) q.push_back(16'hA000 + 16'(i * 37));
        refresh();
        for (int i = 0; i < 24; i++)
            host_read(1'b1, 7'($urandom_range(0, 127)), (i % 2) == 0, i % 3);
        chk("R7 drained", q.size(), 0);

        // R8: empty FIFO reads.
        host_read(1'b1, 7'h05, 1'b1, 2);
        host_read(1'b1, 7'h7E, 1'b0, 0);

        // R9: register reads leave the FIFO alone.
        q.push_back(16'h1111); q.push_back(16'h2222); q.push_back(16'h3333);
        refresh();
        host_read(1'b0, 7'h00, 1'b1, 0);
        host_read(1'b0, 7'h7F, 1'b0, 1);
        host_read(1'b0, 7'h2A, 1'b1, 2);
        chk("R9 fifo untouched", q.size(), 3);
        for (int i = 0; i < 3; i++) host_read(1'b1, 7'(8 * i + i), 1'b0, 2);
        chk("R7 drained again", q.size(), 0);

        repeat (4) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule